// File: doc/BRIEF.md
# Eight-Bit Port Expander Register Core

This core holds the registers and pin control of an eight-bit port expander that sits behind a serial-bus slave. A byte-level front end, which is not part of this block, supplies four one-cycle strobes: one when a transaction starts, one for each received byte, one for each byte the host wants to read, and one when the transaction stops. The core turns these strobes into register writes and reads, drives eight tristate pins as separate data and enable lines, and samples the pin levels.

The first byte written after a start is a command byte. It loads a persistent pointer that selects one of four registers: the live input view, the output latch, the polarity mask and the direction mask. Any further bytes in the same write transaction go to the selected register. To read, the host sends a write transaction that holds only the command byte, and then a read transaction. Each read request captures the selected register into the transmit byte. The pointer stays where it is between transactions.

Top module: `portx_core`

## Requirements
- R1: After reset, all pin enables are low, and the output latch, polarity mask and direction mask hold 0xFF, 0x00 and 0xFF. The pointer holds 0.
- R2: The first byte received after a start strobe loads the pointer from its two low bits: 0 selects input view, 1 the output latch, 2 the polarity mask, 3 the direction mask. The upper six bits are ignored.
- R3: Each further byte in the same transaction writes the selected register. The pointer does not advance, so the last byte wins and the other registers keep their values.
- R4: The pointer keeps its value across stop and start strobes until a new command byte arrives. A read transaction returns the register the pointer selects.
- R5: The input view reports the level on every pin, whether the pin is driven or not, XORed with the polarity mask. Pins pass through a two-stage synchronizer, so a pin change reaches a read capture on the third clock edge after it.
- R6: A byte written while the pointer is 0 changes no register and no pin output.
- R7: Reading the output latch returns the stored value, even when the pin carries a different level.
- R8: A direction bit of 0 sets that pin's enable high and drives the matching output latch bit onto it. A direction bit of 1 sets the enable low.
- R9: A polarity bit of 1 inverts the reported level of that pin. A polarity bit of 0 reports the true level.
- R10: The transmit byte is loaded only on a clock edge where the read request is high. It holds its value between read requests, even while the pins change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Active-low synchronous reset |
| txnStart | input | 1 | Strobe: transaction start seen |
| rxValid | input | 1 | Strobe: a written byte is on rxByte |
| rxByte | input | 8 | Received byte |
| txReq | input | 1 | Strobe: host asks for a read byte |
| stopStrobe | input | 1 | Strobe: transaction stop seen |
| txByte | output | 8 | Byte captured for the host on the last read request |
| pinIn | input | 8 | Sampled pad levels |
| pinOut | output | 8 | Pad output data |
| pinOe | output | 8 | Pad output enable, high means driven |

## Verification
The bench builds the core with its default eight-bit width and two synchronizer stages. With these values, every combination of direction and polarity bits can be reached on the real pin count. The sync latency is short enough to check edge by edge. Between the random passes, an external driver on the resolved pins opposes the output latch, which shows that reads of the latch and reads of the live inputs take different paths.

// File: rtl/portx_pkg.sv
package portx_pkg;
  localparam int SEL_W = 2;

  typedef enum logic [SEL_W-1:0] {
    REG_IN  = 2'd0,
    REG_OUT = 2'd1,
    REG_POL = 2'd2,
    REG_CFG = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic     wrEn;
    logic     rdEn;
    reg_sel_e sel;
  } ctrl_t;
endpackage

// File: rtl/portx_ctrl.sv
module portx_ctrl
  import portx_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             txnStart,
  input  logic             rxValid,
  input  logic [SEL_W-1:0] rxCmd,
  input  logic             txReq,
  input  logic             stopStrobe,
  output ctrl_t            ctrlS
);
  reg_sel_e ptrQ;
  logic     expectCmd;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptrQ      <= REG_IN;
      expectCmd <= 1'b1;
    end else begin
      if (rxValid && expectCmd) ptrQ <= reg_sel_e'(rxCmd);
      if (txnStart || stopStrobe) expectCmd <= 1'b1;
      else if (rxValid)           expectCmd <= 1'b0;
    end
  end

  always_comb begin
    ctrlS.wrEn = rxValid && !expectCmd;
    ctrlS.rdEn = txReq;
    ctrlS.sel  = ptrQ;
  end
endmodule

// File: rtl/portx_dpath.sv
module portx_dpath
  import portx_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrl_t            ctrlS,
  input  logic [WIDTH-1:0] wrData,
  input  logic [WIDTH-1:0] pinIn,
  output logic [WIDTH-1:0] txByte,
  output logic [WIDTH-1:0] pinOut,
  output logic [WIDTH-1:0] pinOe
);
  localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};

  logic [WIDTH-1:0] syncQ [SYNC_STAGES];
  logic [WIDTH-1:0] outReg, polReg, cfgReg;
  logic [WIDTH-1:0] inView, readMux;

  genvar s;
  generate
    for (s = 0; s < SYNC_STAGES; s++) begin : g_sync
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rstN) syncQ[0] <= '0;
          else       syncQ[0] <= pinIn;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rstN) syncQ[s] <= '0;
          else       syncQ[s] <= syncQ[s-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outReg <= ALL_ONES;
      polReg <= '0;
      cfgReg <= ALL_ONES;
    end else if (ctrlS.wrEn) begin
      case (ctrlS.sel)
        REG_OUT: outReg <= wrData;
        REG_POL: polReg <= wrData;
        REG_CFG: cfgReg <= wrData;
        default: ;
      endcase
    end
  end

  assign inView = syncQ[SYNC_STAGES-1] ^ polReg;

  always_comb begin
    case (ctrlS.sel)
      REG_IN:  readMux = inView;
      REG_OUT: readMux = outReg;
      REG_POL: readMux = polReg;
      default: readMux = cfgReg;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)           txByte <= '0;
    else if (ctrlS.rdEn) txByte <= readMux;
  end

  assign pinOut = outReg;
  assign pinOe  = ~cfgReg;
endmodule

// File: rtl/portx_core.sv
module portx_core
  import portx_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             txnStart,
  input  logic             rxValid,
  input  logic [WIDTH-1:0] rxByte,
  input  logic             txReq,
  input  logic             stopStrobe,
  output logic [WIDTH-1:0] txByte,
  input  logic [WIDTH-1:0] pinIn,
  output logic [WIDTH-1:0] pinOut,
  output logic [WIDTH-1:0] pinOe
);
  ctrl_t ctrlS;

  portx_ctrl ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .txnStart   (txnStart),
    .rxValid    (rxValid),
    .rxCmd      (rxByte[SEL_W-1:0]),
    .txReq      (txReq),
    .stopStrobe (stopStrobe),
    .ctrlS      (ctrlS)
  );

  portx_dpath #(.WIDTH(WIDTH), .SYNC_STAGES(SYNC_STAGES)) dpath_i (
    .clk    (clk),
    .rstN   (rstN),
    .ctrlS  (ctrlS),
    .wrData (rxByte),
    .pinIn  (pinIn),
    .txByte (txByte),
    .pinOut (pinOut),
    .pinOe  (pinOe)
  );
endmodule

// File: rtl/portx_chk.sv
module portx_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             rxValid,
  input logic [WIDTH-1:0] rxByte,
  input logic             txReq,
  input logic [WIDTH-1:0] txByte,
  input logic [WIDTH-1:0] pinOut,
  input logic [WIDTH-1:0] pinOe,
  input logic             wrEn,
  input logic [1:0]       sel
);
  // R2
  cmd_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && !wrEn) |=> sel == $past(rxByte[1:0]));

  // R3
  no_incr_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> $stable(sel));

  // R6
  in_write_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && sel == 2'd0) |=> ($stable(pinOut) && $stable(pinOe)));

  // R8
  cfg_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && sel == 2'd3) |=> pinOe == ~$past(rxByte));

  // R8
  out_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && sel == 2'd1) |=> pinOut == $past(rxByte));

  // R8
  pins_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rxValid |=> ($stable(pinOut) && $stable(pinOe)));

  // R10
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !txReq |=> $stable(txByte));
endmodule

bind portx_core portx_chk #(.WIDTH(WIDTH)) chk_i (
  .clk     (clk),
  .rstN    (rstN),
  .rxValid (rxValid),
  .rxByte  (rxByte),
  .txReq   (txReq),
  .txByte  (txByte),
  .pinOut  (pinOut),
  .pinOe   (pinOe),
  .wrEn    (ctrlS.wrEn),
  .sel     (ctrlS.sel)
);

// File: tb/portx_core_tb_top.sv
module portx_core_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic txnStart = 1'b0, rxValid = 1'b0, txReq = 1'b0, stopStrobe = 1'b0;
  logic [W-1:0] rxByte = '0;
  logic [W-1:0] txByte, pinOut, pinOe, pinLevel;
  logic [W-1:0] extDrive = 8'h00;

  logic [W-1:0] mOut = 8'hFF, mPol = 8'h00, mCfg = 8'hFF;
  int unsigned total = 0, bad = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // tristate resolver: driven bits follow pinOut, others the external source
  assign pinLevel = (pinOe & pinOut) | (~pinOe & extDrive);

  portx_core dut_i (
    .clk(clk), .rstN(rstN), .txnStart(txnStart), .rxValid(rxValid),
    .rxByte(rxByte), .txReq(txReq), .stopStrobe(stopStrobe),
    .txByte(txByte), .pinIn(pinLevel), .pinOut(pinOut), .pinOe(pinOe)
  );

  function automatic logic [W-1:0] expRead(input logic [1:0] s);
    case (s)
      2'd0:    return ((~mCfg & mOut) | (mCfg & extDrive)) ^ mPol;
      2'd1:    return mOut;
      2'd2:    return mPol;
      default: return mCfg;
    endcase
  endfunction

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic startT();
    txnStart = 1'b1; @(negedge clk); txnStart = 1'b0;
  endtask

  task automatic stopT();
    stopStrobe = 1'b1; @(negedge clk); stopStrobe = 1'b0;
  endtask

  task automatic sendB(input logic [W-1:0] b);
    rxValid = 1'b1; rxByte = b; @(negedge clk); rxValid = 1'b0;
  endtask

  task automatic rdOne(output logic [W-1:0] v);
    txReq = 1'b1; @(negedge clk); txReq = 1'b0; v = txByte;
  endtask

  task automatic modelWrite(input logic [1:0] s, input logic [W-1:0] d);
    case (s)
      2'd1: mOut = d;
      2'd2: mPol = d;
      2'd3: mCfg = d;
      default: ;
    endcase
  endtask

  task automatic writeReg(input logic [W-1:0] cmd, input logic [W-1:0] d);
    startT(); sendB(cmd); sendB(d); stopT();
    modelWrite(cmd[1:0], d);
  endtask

  task automatic readReg(input logic [1:0] s, output logic [W-1:0] v);
    startT(); sendB({6'h00, s}); stopT();
    startT(); rdOne(v); stopT();
  endtask

  function automatic string tagFor(input logic [1:0] s);
    case (s)
      2'd0:    return "R5";
      2'd1:    return "R7";
      2'd2:    return "R9";
      default: return "R8";
    endcase
  endfunction

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog R10 actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    logic [W-1:0] v, held;
    void'($urandom(32'h5EED_0042));
    extDrive = 8'hA5;
    tick(3);
    rstN = 1'b1;
    tick(4);

    // R1: reset state at the pins and in every register
    chk("R1 pinOe", pinOe, 8'h00);
    chk("R1 pinOut", pinOut, 8'hFF);
    // R4: pointer resets to 0, read with no command returns the input view
    startT(); rdOne(v); stopT();
    chk("R4 R1 ptr reset", v, 8'hA5);
    readReg(2'd1, v); chk("R1 out", v, 8'hFF);
    readReg(2'd2, v); chk("R1 pol", v, 8'h00);
    readReg(2'd3, v); chk("R1 cfg", v, 8'hFF);

    // R2: upper command bits ignored (0xFD selects the output latch)
    writeReg(8'hFD, 8'h3C);
    readReg(2'd1, v); chk("R2 masked cmd", v, 8'h3C);

    // R7: output latch read-back differs from pin level while all pins are inputs
    extDrive = 8'hC3; tick(3);
    readReg(2'd1, v); chk("R7 latch not pin", v, 8'h3C);
    readReg(2'd0, v); chk("R5 input view", v, 8'hC3);

    // R8: direction bits drive the latch onto the pins
    writeReg(8'h03, 8'h0F);
    chk("R8 pinOe", pinOe, 8'hF0);
    chk("R8 driven bits", pinOut & pinOe, 8'h30);
    tick(3);
    readReg(2'd0, v); chk("R5 driven pins seen", v, 8'h33);

    // R9: polarity inversion
    writeReg(8'h02, 8'hFF);
    readReg(2'd0, v); chk("R9 invert all", v, 8'hCC);
    writeReg(8'h02, 8'h00);
    readReg(2'd0, v); chk("R9 true level", v, 8'h33);

    // R3: two data bytes, no auto-increment
    startT(); sendB(8'h02); sendB(8'h11); sendB(8'h5A); stopT();
    mPol = 8'h5A;
    readReg(2'd2, v); chk("R3 last byte wins", v, 8'h5A);
    readReg(2'd3, v); chk("R3 cfg untouched", v, 8'h0F);

    // R6: writes to the input view change nothing
    writeReg(8'h00, 8'h96);
    chk("R6 pinOut", pinOut, 8'h3C);
    chk("R6 pinOe", pinOe, 8'hF0);
    readReg(2'd1, v); chk("R6 out kept", v, 8'h3C);
    readReg(2'd2, v); chk("R6 pol kept", v, 8'h5A);
    readReg(2'd3, v); chk("R6 cfg kept", v, 8'h0F);

    // R4: pointer survives several transactions
    startT(); sendB(8'h01); stopT();
    startT(); stopT();
    startT(); rdOne(v); stopT();
    startT(); rdOne(v); stopT();
    chk("R4 ptr persists", v, 8'h3C);

    // R5: sync latency, R10: hold between reads
    writeReg(8'h02, 8'h00);
    writeReg(8'h03, 8'hFF);
    extDrive = 8'h00; tick(4);
    startT(); sendB(8'h00); stopT();
    startT();
    extDrive = 8'h7E;
    txReq = 1'b1;
    @(negedge clk); chk("R5 edge1 old", txByte, 8'h00);
    @(negedge clk); chk("R5 edge2 old", txByte, 8'h00);
    @(negedge clk); chk("R5 edge3 new", txByte, 8'h7E);
    txReq = 1'b0;
    held = txByte;
    extDrive = 8'h81; tick(5);
    chk("R10 hold", txByte, held);
    stopT();

    // random passes checked against the bench model
    for (int i = 0; i < 150; i++) begin
      logic [1:0] ws, rs;
      logic [W-1:0] d;
      ws = 2'($urandom % 4);
      d  = 8'($urandom);
      writeReg({6'($urandom), ws}, d);
      extDrive = 8'($urandom);
      tick(3);
      rs = 2'($urandom % 4);
      readReg(rs, v);
      chk(tagFor(rs), v, expRead(rs));
      chk("R8 rand pinOe", pinOe, ~mCfg);
      chk("R8 rand drive", pinOut & ~mCfg, mOut & ~mCfg);
    end

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule